// File: doc/BRIEF.md
# Timer with Match and Capture

This block is a 32-bit up-counter fed by a 32-bit prescaler, with four compare channels and four snapshot channels. The counter steps once every time the prescaler reaches its programmed limit. Advances come either from every cycle of the block clock (the peripheral clock) or from edges on one chosen capture input, so the same hardware serves as an interval timer or as an external event counter.

Each compare channel holds a value. When the counter is about to step away from that value, the channel can do any mix of three things: flag an interrupt, send the counter back to zero, or halt the timer. The channel also drives its own output pin, which it can clear, set, toggle or leave alone. Each capture channel watches its input through a two-flop synchronizer. On a rising edge, a falling edge or either edge, it stores the current count and can raise a sticky interrupt flag.

Software programs the block through a write-only register port. It reads back the count, the prescaler, the captured values, the pin states and the flags directly on output ports.

Top module: `match_capture_timer`

## Requirements
- R1: The prescaler advances on every advance tick. On a tick where the prescaler is at or above its limit (address 1), it returns to 0 and the counter steps. A limit of L therefore gives one counter step per L+1 ticks. Both values wrap modulo 2^32.
- R2: Address 0 is the control register: bit 0 enables counting and bit 1 is a hold bit. While hold reads 1, the counter and the prescaler are forced to 0 on every edge. After reset every register, output and flag is 0.
- R3: Address 2 holds the match actions, three bits per channel i: bit 3i is the interrupt enable, bit 3i+1 resets the counter and bit 3i+2 stops the timer. A match on channel i occurs on a counter step (R1) while the count equals the value of channel i. On a match with reset the counter becomes 0. On a match with stop only, the counter keeps its value. On any match with stop, the enable bit is cleared in that same edge, and this overrides a control write in that edge.
- R4: Address 3 holds the pin action, two bits per channel at bits 2i+1:2i: 00 leaves the pin alone, 01 drives it low, 10 drives it high and 11 toggles it. The pin changes only in the edge where its channel matches.
- R5: Address 4 holds the capture settings, three bits per channel i: bit 3i captures on a rising edge, bit 3i+1 captures on a falling edge and bit 3i+2 is the interrupt enable. A capture stores the counter value held before that edge.
- R6: Address 5 selects the advance source. Bits 1:0 = 00 means every clock cycle; 01, 10 and 11 mean rising, falling or both edges of the synchronized capture input whose index is in bits 3:2. An external input must hold each level for at least two clock cycles.
- R7: The flags are sticky, with bits 3:0 for the match channels and bits 7:4 for the capture channels. Writing a one to a bit at address 6 clears that flag, and a new event in the same edge wins over the clear. irq is high whenever any flag is set.
- R8: Capture inputs are sampled through two flops. A level change that is present before clock edge k is acted on at edge k+2.
- R9: Addresses 8 to 11 hold the compare values of channels 0 to 3. Writes to every register take effect from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| cap_in | input | 4 | Asynchronous capture / count inputs |
| count | output | 32 | Counter value |
| prescale | output | 32 | Prescaler value |
| cap_flat | output | 128 | Captured values, channel i at bits 32i+31:32i |
| match_out | output | 4 | Match-driven output pins |
| int_flags | output | 8 | Sticky interrupt flags |
| irq | output | 1 | Any flag set |

## Verification
The bench concentrates on the cases where the timing rules interact. These include a compare value equal to the count while the prescaler is still mid-period: an early comparator would fire every cycle instead of once per step. A channel carrying both stop and reset must leave a zero count and a halted timer; getting the precedence wrong lets the count restart or freeze at the compare value. It also covers a flag clear that lands in the same edge as a new event, where a design that lets the clear win drops the event. Finally it checks the capture latency of exactly three edges and counting on the chosen edge polarity of a slow external input. A missing synchronizer stage or a wrong edge polarity shifts every captured value or count by one.

// File: rtl/match_capture_timer.sv
module match_capture_timer #(
  parameter int CW  = 32,
  parameter int NCH = 4,
  parameter int AW  = 4
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [CW-1:0]      wr_data,
  input  logic [NCH-1:0]     cap_in,
  output logic [CW-1:0]      count,
  output logic [CW-1:0]      prescale,
  output logic [NCH*CW-1:0]  cap_flat,
  output logic [NCH-1:0]     match_out,
  output logic [2*NCH-1:0]   int_flags,
  output logic               irq
);
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int NF = 2 * NCH;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PRE  = AW'(1);
  localparam logic [AW-1:0] A_MCTL = AW'(2);
  localparam logic [AW-1:0] A_OCTL = AW'(3);
  localparam logic [AW-1:0] A_CCTL = AW'(4);
  localparam logic [AW-1:0] A_CSRC = AW'(5);
  localparam logic [AW-1:0] A_ICLR = AW'(6);
  localparam int A_MR0 = 8;

  logic              run, hold;
  logic [CW-1:0]     pr, cnt, pre;
  logic [3*NCH-1:0]  mctl, cctl;
  logic [2*NCH-1:0]  octl;
  logic [1:0]        cmode;
  logic [SW-1:0]     csel;
  logic [CW-1:0]     mr  [NCH];
  logic [CW-1:0]     cap [NCH];
  logic [NCH-1:0]    s1, s2, s3;
  logic [NCH-1:0]    rise, fall, m_hit, c_hit, m_int, m_rst, m_stop, c_int;
  logic [NCH-1:0]    mout;
  logic [NF-1:0]     flags, clr;
  logic              ext_edge, tick, term, any_rst, any_stop;

  assign rise     = s2 & ~s3;
  assign fall     = ~s2 & s3;
  assign ext_edge = (cmode[0] & rise[csel]) | (cmode[1] & fall[csel]);
  assign tick     = run & ~hold & ((cmode == 2'b00) | ext_edge);
  assign term     = tick & (pre >= pr);
  assign any_rst  = |(m_hit & m_rst);
  assign any_stop = |(m_hit & m_stop);
  assign clr      = (wr_en && wr_addr == A_ICLR) ? wr_data[NF-1:0] : '0;

  assign count     = cnt;
  assign prescale  = pre;
  assign match_out = mout;
  assign int_flags = flags;
  assign irq       = |flags;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign m_int[i]  = mctl[3*i];
      assign m_rst[i]  = mctl[3*i+1];
      assign m_stop[i] = mctl[3*i+2];
      assign c_int[i]  = cctl[3*i+2];
      assign m_hit[i]  = term & (cnt == mr[i]);
      assign c_hit[i]  = (cctl[3*i] & rise[i]) | (cctl[3*i+1] & fall[i]);
      assign cap_flat[i*CW +: CW] = cap[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mr[i]   <= '0;
          cap[i]  <= '0;
          mout[i] <= 1'b0;
        end else begin
          if (wr_en && wr_addr == AW'(A_MR0 + i)) mr[i] <= wr_data;
          if (c_hit[i]) cap[i] <= cnt;
          if (m_hit[i]) begin
            case (octl[2*i +: 2])
              2'b01:   mout[i] <= 1'b0;
              2'b10:   mout[i] <= 1'b1;
              2'b11:   mout[i] <= ~mout[i];
              default: mout[i] <= mout[i];
            endcase
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; hold <= 1'b0; pr <= '0;
      mctl <= '0; octl <= '0; cctl <= '0; cmode <= '0; csel <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: {hold, run} <= wr_data[1:0];
          A_PRE:  pr <= wr_data;
          A_MCTL: mctl <= wr_data[3*NCH-1:0];
          A_OCTL: octl <= wr_data[2*NCH-1:0];
          A_CCTL: cctl <= wr_data[3*NCH-1:0];
          A_CSRC: begin cmode <= wr_data[1:0]; csel <= wr_data[2 +: SW]; end
          default: ;
        endcase
      end
      if (any_stop) run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pre <= '0;
    end else if (hold) begin
      cnt <= '0; pre <= '0;
    end else if (term) begin
      pre <= '0;
      if (any_rst)       cnt <= '0;
      else if (!any_stop) cnt <= cnt + 1'b1;
    end else if (tick) begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; flags <= '0;
    end else begin
      s1 <= cap_in;
      s2 <= s1;
      s3 <= s2;
      flags <= (flags & ~clr) | {c_hit & c_int, m_hit & m_int};
    end
  end

  a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0 && prescale == '0));
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0));
  a_r3_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    any_stop |=> !run);
  a_r4_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|m_hit) |=> $stable(mout));
  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~$past(clr)) & ~flags) == '0));
endmodule

// File: tb/tb_match_capture_timer.sv
module tb_match_capture_timer;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [3:0] cap_in = 0;
  logic [31:0] count, prescale;
  logic [127:0] cap_flat;
  logic [3:0] match_out;
  logic [7:0] int_flags;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  match_capture_timer dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .cap_in,
    .count, .prescale, .cap_flat, .match_out, .int_flags, .irq);

  // behavioural reference
  bit m_run, m_hold;
  logic [31:0] m_pr, m_tc, m_pc, m_mr[4], m_cap[4];
  logic [11:0] m_mctl, m_cctl;
  logic [7:0] m_octl, m_flags;
  logic [1:0] m_mode;
  int m_sel;
  logic [3:0] m_s1, m_s2, m_s3, m_out;

  always @(posedge clk or negedge rst_n) begin : model
    bit tick, term, do_rst, do_stop, edge_ok;
    logic [3:0] r, f, mh, ch;
    logic [7:0] clrm;
    if (!rst_n) begin
      m_run = 0; m_hold = 0; m_pr = 0; m_tc = 0; m_pc = 0;
      m_mctl = 0; m_cctl = 0; m_octl = 0; m_flags = 0; m_mode = 0; m_sel = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_out = 0;
      for (int i = 0; i < 4; i++) begin m_mr[i] = 0; m_cap[i] = 0; end
    end else begin
      r = m_s2 & ~m_s3;
      f = m_s3 & ~m_s2;
      if (m_mode == 0) edge_ok = 1;
      else edge_ok = (m_mode[0] && r[m_sel]) || (m_mode[1] && f[m_sel]);
      tick = m_run && !m_hold && edge_ok;
      term = tick && (m_pc >= m_pr);
      do_rst = 0; do_stop = 0;
      clrm = (wr_en && wr_addr == 6) ? wr_data[7:0] : 8'h0;
      m_flags = m_flags & ~clrm;
      for (int i = 0; i < 4; i++) begin
        mh[i] = term && (m_tc == m_mr[i]);
        ch[i] = (m_cctl[3*i] && r[i]) || (m_cctl[3*i+1] && f[i]);
        if (mh[i] && m_mctl[3*i+1]) do_rst = 1;
        if (mh[i] && m_mctl[3*i+2]) do_stop = 1;
        if (mh[i] && m_mctl[3*i]) m_flags[i] = 1;
        if (ch[i] && m_cctl[3*i+2]) m_flags[4+i] = 1;
        if (ch[i]) m_cap[i] = m_tc;
        if (mh[i]) begin
          if (m_octl[2*i +: 2] == 2'b01) m_out[i] = 0;
          else if (m_octl[2*i +: 2] == 2'b10) m_out[i] = 1;
          else if (m_octl[2*i +: 2] == 2'b11) m_out[i] = !m_out[i];
        end
      end
      if (m_hold) begin m_tc = 0; m_pc = 0; end
      else if (term) begin
        m_pc = 0;
        if (do_rst) m_tc = 0;
        else if (!do_stop) m_tc = m_tc + 1;
      end else if (tick) m_pc = m_pc + 1;
      if (wr_en) begin
        case (wr_addr)
          0: begin m_run = wr_data[0]; m_hold = wr_data[1]; end
          1: m_pr = wr_data;
          2: m_mctl = wr_data[11:0];
          3: m_octl = wr_data[7:0];
          4: m_cctl = wr_data[11:0];
          5: begin m_mode = wr_data[1:0]; m_sel = int'(wr_data[3:2]); end
          8, 9, 10, 11: m_mr[wr_addr - 8] = wr_data;
          default: ;
        endcase
      end
      if (do_stop) m_run = 0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
    end
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 R3 R6 count", count, m_tc);
    chk("R1 prescale", prescale, m_pc);
    chk("R4 R9 match_out", match_out, m_out);
    chk("R5 R8 capture", cap_flat, {m_cap[3], m_cap[2], m_cap[1], m_cap[0]});
    chk("R7 flags", int_flags, m_flags);
    chk("R7 irq", irq, |m_flags);
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic pulse(int ch, int hi, int lo);
    cap_in[ch] = 1; cyc(hi); cap_in[ch] = 0; cyc(lo);
  endtask

  task automatic summary;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] c0;
    logic [15:0] lf;
    cyc(3); rst_n = 1; @(negedge clk);
    chk("R2 reset count", count, 0);
    chk("R2 reset pins", match_out, 0);
    chk("R2 reset flags", {irq, int_flags}, 0);
    // R1: plain timer, then prescaled
    wr(5, 0); wr(0, 1); cyc(20);
    wr(1, 3); cyc(40);
    wr(1, 0);
    // R3 R4 R9: matches with mixed actions
    wr(0, 2); wr(0, 1);
    wr(8, 10); wr(9, 5); wr(10, 7); wr(11, 200);
    wr(2, 12'b000_001_000_011);
    wr(3, 8'b00_01_10_11);
    cyc(60);
    wr(1, 2); cyc(80);
    // R7: partial clear, then clear with concurrent set
    wr(6, 8'h02); cyc(3);
    wr(6, 8'hFF); cyc(30);
    // R7 literal: stop timer, clear all
    wr(0, 0); wr(6, 8'hFF); cyc(2);
    chk("R7 clear all", int_flags, 0);
    chk("R7 irq low", irq, 0);
    // R8 literal latency with pr=0 and no resets
    wr(2, 0); wr(1, 0); wr(4, 12'b100_100_100_101); wr(0, 2); wr(0, 1);
    cyc(5);
    c0 = count; cap_in[0] = 1; cyc(3);
    chk("R8 capture latency", cap_flat[31:0], c0 + 2);
    // R5: edge selections across channels
    wr(4, 12'b111_110_101_011);
    for (int k = 0; k < 12; k++) begin cap_in = 4'(k * 5 + 3); cyc(3 + k % 3); end
    cap_in = 0; cyc(5);
    // R2 hold
    wr(1, 4); cyc(7); wr(0, 3); cyc(6);
    chk("R2 hold count", count, 0);
    chk("R2 hold prescale", prescale, 0);
    // R3 stop+reset on ch0
    wr(1, 0); wr(8, 6); wr(2, 12'b000_000_000_110); wr(3, 0); wr(0, 1);
    cyc(20);
    chk("R3 stop+reset count", count, 0); cyc(5);
    chk("R3 stop+reset stays", count, 0);
    // R3 stop only on ch1: count holds at compare value
    wr(0, 1); wr(9, 9); wr(2, 12'b000_000_101_000); cyc(20);
    chk("R3 stop holds value", count, 9);
    // R6 counter mode rising on input 2
    wr(2, 0); wr(4, 0); wr(5, (2 << 2) | 1); wr(0, 2); wr(0, 1);
    for (int k = 0; k < 5; k++) pulse(2, 2, 2);
    cyc(3);
    chk("R6 rising count", count, 5);
    // R6 both edges on input 1 with prescaler 1, falling on input 3
    wr(5, (1 << 2) | 3); wr(1, 1);
    for (int k = 0; k < 6; k++) pulse(1, 2, 3);
    wr(5, (3 << 2) | 2);
    for (int k = 0; k < 6; k++) pulse(3, 3, 2);
    // mixed traffic
    wr(1, 0); wr(5, 0); wr(8, 13); wr(9, 4); wr(10, 40); wr(11, 25);
    wr(2, 12'b011_001_011_011); wr(3, 8'hE4); wr(4, 12'b111_110_101_111);
    wr(0, 1);
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cap_in = lf[3:0];
      if (lf[9:6] == 0) wr(6, {24'h0, lf[15:8]});
      else if (lf[9:6] == 1) wr(0, 1);
      else cyc(2);
    end
    cyc(5);
    summary();
  end
endmodule